// File: doc/BRIEF.md
# Multi-Mode DMA Channel Engine

This block is a single DMA channel that moves 32-bit words between a word-wide memory port and a peripheral port. Software programs three registers: a start address, a block-control word (a word count in the low half and a block count in the high half), and a channel-control word. The channel-control word selects the direction, the address step sign and the synchronisation mode, and it carries the start/busy and manual trigger flags. The engine then walks memory and hands each word to the peripheral, or takes each word from the peripheral, as the peripheral's ready signal allows.

Three synchronisation modes exist. A burst moves one block when software triggers it. The block mode repeats a block until the block count runs out. The list mode follows a chain of packets in memory. Each packet starts with a header word: the header's top byte is the payload length, and its low 24 bits link to the next packet. The engine reports a finished transfer with a one-cycle completion pulse. If it reaches an address outside the legal window, it aborts with a one-cycle error pulse.

Top module: `dma_chan_engine`

## Requirements
- R1: A write to channel control stores the value ANDed with 0x71770703. A write to the start address keeps only bits 23:0. Selector codes on `cfg_sel`: 0 start address, 1 block control, 2 channel control.
- R2: Channel-control field positions: bit 0 sets the direction (1 = memory to peripheral, 0 = peripheral to memory). Bit 1 makes the address step downwards. Bits 10:9 hold the mode (0 burst, 1 repeated blocks, 2 or 3 list). Bit 24 is start/busy. Bit 28 is the manual trigger.
- R3: In burst mode, a block starts only once bits 24 and 28 are both set. The block moves the number of words in block-control bits 15:0, where 0 means 65536, and the channel then completes.
- R4: After every word moved, the current address steps by +4, or by −4 when bit 1 is set, modulo 2^24. The memory port carries the current address ANDed with 0x1FFFFC.
- R5: In block mode, each block start decrements block-control bits 31:16. At each block end the start address takes the current address. The channel completes at a block end that finds bits 31:16 equal to zero.
- R6: In list mode, the engine reads a header at the start address. The header's bits 31:24 give the payload length and bits 23:0 become the new start address. The payload follows the header word. A length of zero moves no payload. The list completes after the packet whose link is 0xFFFFFF.
- R7: When an address with bit 23 set is about to be used, whether the current address or a header address, the engine makes no access. It clears bits 24 and 28, emits one `err_pulse` and stops.
- R8: On completion the engine clears control bits 24 and 28 and emits one `done_pulse`. The pulse is high in the first cycle that shows those bits cleared, and the two pulses never coincide.
- R9: Clearing bit 24 while a block is in flight lets that block finish. The engine then stops without a completion pulse and without starting another block.
- R10: A word moves only in a cycle where `per_ready` is high. While it is low the engine holds its address and count, so no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector (0 address, 1 block control, 2 channel control) |
| cfg_wdata | input | 32 | Register write data |
| base_o | output | 24 | Start address register |
| blkctl_o | output | 32 | Block-control register |
| chctl_o | output | 32 | Channel-control register |
| mem_rd | output | 1 | Memory word read this cycle |
| mem_wr | output | 1 | Memory word write this cycle |
| mem_addr | output | 24 | Memory byte address, masked |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| per_ready | input | 1 | Peripheral can move a word this cycle |
| per_push | output | 1 | Word delivered to the peripheral |
| per_wdata | output | 32 | Data delivered to the peripheral |
| per_pop | output | 1 | Word taken from the peripheral |
| per_rdata | input | 32 | Data offered by the peripheral |
| done_pulse | output | 1 | One-cycle completion pulse |
| err_pulse | output | 1 | One-cycle address-error pulse |

## Verification
The assertions assume that memory answers a read in the same cycle and that `per_ready` is meaningful in every cycle. They also assume that software never writes channel control in the same cycle the engine finishes, since the write would take priority over the hardware clear of bits 24 and 28. The stimulus changes registers only while the engine is idle or deliberately stalled. The one exception is the cancel case, where the write lands while `per_ready` is held low, so no block end can coincide with it. Block counts are kept small and nonzero, and every list chain ends on the 0xFFFFFF marker.

// File: rtl/dma_pkg.sv
package dma_pkg;
   localparam logic [31:0] CTRL_WR_MASK = 32'h7177_0703;
   localparam int CB_DIR   = 0;
   localparam int CB_DEC   = 1;
   localparam int CB_MODE  = 9;
   localparam int CB_BUSY  = 24;
   localparam int CB_TRIG  = 28;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_LOAD = 2'd1,
      SEQ_MOVE = 2'd2
   } seq_state_t;

   typedef enum logic [1:0] {
      CFG_BASE  = 2'd0,
      CFG_BLOCK = 2'd1,
      CFG_CTRL  = 2'd2
   } cfg_sel_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int ADDR_W = 24,
   parameter int STEP   = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              dec_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   generate
      if (STEP <= 0) begin : g_bad_step
         $error("dma_addr_step: STEP must be positive");
      end
   endgenerate

   assign addr_o = dec_i ? (addr_i - STEP_V) : (addr_i + STEP_V);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs import dma_pkg::*; #(
   parameter int ADDR_W = 24,
   parameter int WORD_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              hw_base_we,
   input  logic [ADDR_W-1:0] hw_base_d,
   input  logic              hw_blk_dec,
   input  logic              hw_stop,
   output logic [ADDR_W-1:0] base_q,
   output logic [WORD_W-1:0] blk_q,
   output logic [WORD_W-1:0] ctrl_q,
   output logic              start_edge
);
   localparam int HI_W = WORD_W - CNT_W;
   localparam logic [WORD_W-1:0] MASK = WORD_W'(CTRL_WR_MASK);

   generate
      if (WORD_W < 29 || ADDR_W > WORD_W || CNT_W >= WORD_W) begin : g_bad_width
         $error("dma_chan_regs: register widths out of range");
      end
   endgenerate

   logic wr_base, wr_blk, wr_ctrl;
   assign wr_base = cfg_we && (cfg_sel == CFG_BASE);
   assign wr_blk  = cfg_we && (cfg_sel == CFG_BLOCK);
   assign wr_ctrl = cfg_we && (cfg_sel == CFG_CTRL);

   assign start_edge = wr_ctrl && !ctrl_q[CB_BUSY] && cfg_wdata[CB_BUSY];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         blk_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_base)
            base_q <= cfg_wdata[ADDR_W-1:0];
         else if (hw_base_we)
            base_q <= hw_base_d;

         if (wr_blk)
            blk_q <= cfg_wdata;
         else if (hw_blk_dec)
            blk_q[WORD_W-1:CNT_W] <= blk_q[WORD_W-1:CNT_W] - HI_W'(1);

         if (wr_ctrl)
            ctrl_q <= cfg_wdata & MASK;
         else if (hw_stop) begin
            ctrl_q[CB_BUSY] <= 1'b0;
            ctrl_q[CB_TRIG] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq import dma_pkg::*; #(
   parameter int              ADDR_W   = 24,
   parameter int              WORD_W   = 32,
   parameter int              CNT_W    = 16,
   parameter int              HDR_W    = 8,
   parameter int              ERR_BIT  = 23,
   parameter bit              LIST_EN  = 1'b1,
   parameter logic [ADDR_W-1:0] MEM_MASK = 24'h1F_FFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              trig_i,
   input  logic              dir_i,
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] base_q,
   input  logic [WORD_W-1:0] blk_q,
   input  logic              start_edge,
   input  logic              per_ready,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic [ADDR_W-1:0] cur_nxt,
   input  logic [ADDR_W-1:0] base_inc,
   output logic [ADDR_W-1:0] cur_o,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              per_push,
   output logic              per_pop,
   output logic              base_we,
   output logic [ADDR_W-1:0] base_d,
   output logic              blk_dec,
   output logic              hw_stop,
   output logic              done_pulse,
   output logic              err_pulse
);
   localparam int CW = CNT_W + 1;
   localparam int HI_W = WORD_W - CNT_W;
   localparam logic [ADDR_W-1:0] END_LINK = {ADDR_W{1'b1}};
   localparam logic [CW-1:0] FULL_BLOCK = {1'b1, {CNT_W{1'b0}}};

   generate
      if (HDR_W + ADDR_W > WORD_W || HDR_W > CNT_W || ERR_BIT >= ADDR_W) begin : g_bad_cfg
         $error("dma_chan_seq: header or address layout does not fit");
      end
   endgenerate

   seq_state_t st, nst;
   logic [ADDR_W-1:0] cur, cur_d;
   logic [CW-1:0]     wcnt, wcnt_d;
   logic              done_d, err_d;
   logic              is_list, is_blocks, sel_base;

   generate
      if (LIST_EN) begin : g_list
         assign is_list = mode_i[1];
      end else begin : g_nolist
         assign is_list = 1'b0;
      end
   endgenerate
   assign is_blocks = (mode_i == 2'b01);

   logic [HDR_W-1:0]  hdr_cnt;
   logic [ADDR_W-1:0] hdr_link;
   logic [CW-1:0]     blk_load;
   assign hdr_cnt  = mem_rdata[WORD_W-1 -: HDR_W];
   assign hdr_link = mem_rdata[ADDR_W-1:0];
   assign blk_load = (blk_q[CNT_W-1:0] == '0) ? FULL_BLOCK : {1'b0, blk_q[CNT_W-1:0]};

   always_comb begin
      nst      = st;
      cur_d    = cur;
      wcnt_d   = wcnt;
      mem_rd   = 1'b0;
      mem_wr   = 1'b0;
      per_push = 1'b0;
      per_pop  = 1'b0;
      base_we  = 1'b0;
      base_d   = base_q;
      blk_dec  = 1'b0;
      hw_stop  = 1'b0;
      done_d   = 1'b0;
      err_d    = 1'b0;
      sel_base = 1'b0;
      case (st)
         SEQ_LOAD: begin
            if (!busy_i) begin
               nst = SEQ_IDLE;
            end else if (is_list) begin
               sel_base = 1'b1;
               if (base_q[ERR_BIT]) begin
                  err_d   = 1'b1;
                  hw_stop = 1'b1;
                  nst     = SEQ_IDLE;
               end else begin
                  mem_rd  = 1'b1;
                  base_we = 1'b1;
                  base_d  = hdr_link;
                  cur_d   = base_inc;
                  wcnt_d  = CW'(hdr_cnt);
                  if (hdr_cnt != '0)
                     nst = SEQ_MOVE;
                  else if (hdr_link == END_LINK) begin
                     done_d  = 1'b1;
                     hw_stop = 1'b1;
                     nst     = SEQ_IDLE;
                  end
               end
            end else if (is_blocks || trig_i) begin
               cur_d   = base_q;
               wcnt_d  = blk_load;
               blk_dec = is_blocks;
               nst     = SEQ_MOVE;
            end
         end
         SEQ_MOVE: begin
            if (cur[ERR_BIT]) begin
               err_d   = 1'b1;
               hw_stop = 1'b1;
               nst     = SEQ_IDLE;
            end else if (per_ready) begin
               mem_rd   = dir_i;
               mem_wr   = !dir_i;
               per_push = dir_i;
               per_pop  = !dir_i;
               cur_d    = cur_nxt;
               wcnt_d   = wcnt - CW'(1);
               if (wcnt == CW'(1)) begin
                  if (!busy_i) begin
                     nst = SEQ_IDLE;
                  end else if (is_list) begin
                     if (base_q == END_LINK) begin
                        done_d  = 1'b1;
                        hw_stop = 1'b1;
                        nst     = SEQ_IDLE;
                     end else
                        nst = SEQ_LOAD;
                  end else if (is_blocks) begin
                     base_we = 1'b1;
                     base_d  = cur_nxt;
                     if (blk_q[WORD_W-1:CNT_W] == HI_W'(0)) begin
                        done_d  = 1'b1;
                        hw_stop = 1'b1;
                        nst     = SEQ_IDLE;
                     end else
                        nst = SEQ_LOAD;
                  end else begin
                     done_d  = 1'b1;
                     hw_stop = 1'b1;
                     nst     = SEQ_IDLE;
                  end
               end
            end
         end
         default: ;
      endcase
      if (start_edge) begin
         nst    = SEQ_LOAD;
         wcnt_d = '0;
      end
   end

   assign mem_addr = (sel_base ? base_q : cur) & MEM_MASK;
   assign cur_o    = cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SEQ_IDLE;
         cur        <= '0;
         wcnt       <= '0;
         done_pulse <= 1'b0;
         err_pulse  <= 1'b0;
      end else begin
         st         <= nst;
         cur        <= cur_d;
         wcnt       <= wcnt_d;
         done_pulse <= done_d;
         err_pulse  <= err_d;
      end
   end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine import dma_pkg::*; #(
   parameter int              ADDR_W   = 24,
   parameter int              WORD_W   = 32,
   parameter int              CNT_W    = 16,
   parameter int              HDR_W    = 8,
   parameter int              ERR_BIT  = 23,
   parameter int              STEP     = 4,
   parameter bit              LIST_EN  = 1'b1,
   parameter logic [ADDR_W-1:0] MEM_MASK = 24'h1F_FFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] base_o,
   output logic [WORD_W-1:0] blkctl_o,
   output logic [WORD_W-1:0] chctl_o,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              per_ready,
   output logic              per_push,
   output logic [WORD_W-1:0] per_wdata,
   output logic              per_pop,
   input  logic [WORD_W-1:0] per_rdata,
   output logic              done_pulse,
   output logic              err_pulse
);
   logic              hw_base_we, hw_blk_dec, hw_stop, start_edge;
   logic [ADDR_W-1:0] hw_base_d, cur, cur_nxt, base_inc;

   dma_chan_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .hw_base_we(hw_base_we), .hw_base_d(hw_base_d),
      .hw_blk_dec(hw_blk_dec), .hw_stop(hw_stop),
      .base_q(base_o), .blk_q(blkctl_o), .ctrl_q(chctl_o),
      .start_edge(start_edge)
   );

   dma_addr_step #(.ADDR_W(ADDR_W), .STEP(STEP)) step_cur_i (
      .addr_i(cur), .dec_i(chctl_o[CB_DEC]), .addr_o(cur_nxt)
   );

   dma_addr_step #(.ADDR_W(ADDR_W), .STEP(STEP)) step_hdr_i (
      .addr_i(base_o), .dec_i(1'b0), .addr_o(base_inc)
   );

   dma_chan_seq #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .HDR_W(HDR_W),
      .ERR_BIT(ERR_BIT), .LIST_EN(LIST_EN), .MEM_MASK(MEM_MASK)
   ) seq_i (
      .clk(clk), .rst_n(rst_n),
      .busy_i(chctl_o[CB_BUSY]), .trig_i(chctl_o[CB_TRIG]),
      .dir_i(chctl_o[CB_DIR]), .mode_i(chctl_o[CB_MODE+1:CB_MODE]),
      .base_q(base_o), .blk_q(blkctl_o), .start_edge(start_edge),
      .per_ready(per_ready), .mem_rdata(mem_rdata),
      .cur_nxt(cur_nxt), .base_inc(base_inc), .cur_o(cur),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .per_push(per_push), .per_pop(per_pop),
      .base_we(hw_base_we), .base_d(hw_base_d), .blk_dec(hw_blk_dec),
      .hw_stop(hw_stop), .done_pulse(done_pulse), .err_pulse(err_pulse)
   );

   assign per_wdata = mem_rdata;
   assign mem_wdata = per_rdata;
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] chctl_o,
   input logic        mem_rd,
   input logic        mem_wr,
   input logic        per_ready,
   input logic        per_push,
   input logic        per_pop,
   input logic        done_pulse,
   input logic        err_pulse
);
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_pulse && err_pulse)); // R8
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (!chctl_o[24] && !chctl_o[28])); // R8
   AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (!chctl_o[24] && !chctl_o[28])); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse); // R8
   AST_XFER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (per_push || per_pop) |-> per_ready); // R10
   AST_PUSH_READS: assert property (@(posedge clk) disable iff (!rst_n)
      per_push |-> (mem_rd && !mem_wr && !per_pop)); // R2
   AST_POP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      per_pop |-> (mem_wr && !mem_rd)); // R2
   AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (chctl_o & ~32'h7177_0703) == 32'h0); // R1
endmodule

bind dma_chan_engine dma_chan_engine_chk chk_i (
   .clk(clk), .rst_n(rst_n), .chctl_o(chctl_o),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .per_ready(per_ready),
   .per_push(per_push), .per_pop(per_pop),
   .done_pulse(done_pulse), .err_pulse(err_pulse)
);

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [23:0] base_o;
   logic [31:0] blkctl_o, chctl_o;
   logic        mem_rd, mem_wr;
   logic [23:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        per_ready = 1'b1;
   logic        per_push, per_pop;
   logic [31:0] per_wdata, per_rdata;
   logic        done_pulse, err_pulse;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int rdy_mode = 0;
   int push_n = 0, pop_n = 0, done_n = 0, err_n = 0;
   logic [31:0] push_dat [0:255];
   logic [23:0] push_adr [0:255];
   logic [23:0] pop_adr  [0:255];
   logic [31:0] mem [0:1023];

   always #2 clk = ~clk;

   dma_chan_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .base_o(base_o), .blkctl_o(blkctl_o),
      .chctl_o(chctl_o), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .per_ready(per_ready), .per_push(per_push), .per_wdata(per_wdata),
      .per_pop(per_pop), .per_rdata(per_rdata),
      .done_pulse(done_pulse), .err_pulse(err_pulse)
   );

   assign mem_rdata = mem[mem_addr[11:2]];
   assign per_rdata = 32'hA000_0000 | pop_n;

   function automatic logic [31:0] fill(input logic [23:0] a);
      return 32'h5A00_0000 | {20'd0, a[11:2]};
   endfunction

   always @(negedge clk) begin
      cyc = cyc + 1;
      per_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ((cyc % 3) != 0) : 1'b0;
   end

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (per_push) begin
            push_dat[push_n[7:0]] = per_wdata;
            push_adr[push_n[7:0]] = mem_addr;
            push_n = push_n + 1;
         end
         if (per_pop) begin
            mem[mem_addr[11:2]] = mem_wdata;
            pop_adr[pop_n[7:0]] = mem_addr;
            pop_n = pop_n + 1;
         end
         if (done_pulse) done_n = done_n + 1;
         if (err_pulse)  err_n  = err_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic wait_busy_clear();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!chctl_o[24]) break;
      end
      idle(3);
   endtask

   initial begin
      #(4 * 150000);
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int p0, d0, e0, q0;
      for (int i = 0; i < 1024; i++) mem[i] = fill(24'(i * 4));
      // list chain: 0x200 -> 0x300 (empty) -> 0x320 -> end
      mem[12'h200 >> 2] = 32'h0200_0300;
      mem[12'h300 >> 2] = 32'h0000_0320;
      mem[12'h320 >> 2] = 32'h01FF_FFFF;
      // list whose link points into the illegal window
      mem[12'h3A0 >> 2] = 32'h0180_0010;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // reset state
      chk(chctl_o == 0 && base_o == 0 && blkctl_o == 0 && !done_pulse && !err_pulse,
          "R8 reset", chctl_o, 32'h0);

      // R1 masking
      wr(2'd2, 32'hFEFF_FFFF);
      idle(1);
      chk(chctl_o == 32'h7077_0703, "R1 ctrl mask", chctl_o, 32'h7077_0703);
      wr(2'd0, 32'hFFFF_FFFF);
      idle(1);
      chk(base_o == 24'hFF_FFFF, "R1 base width", {8'h0, base_o}, 32'h00FF_FFFF);
      wr(2'd2, 32'h0);

      // R3 burst needs trigger
      rdy_mode = 0;
      wr(2'd0, 32'h100); wr(2'd1, 32'h2);
      p0 = push_n; d0 = done_n;
      wr(2'd2, 32'h0100_0001);
      idle(10);
      chk(push_n == p0 && chctl_o[24], "R3 no trigger no move", push_n - p0, 0);
      wr(2'd2, 32'h1100_0001);
      wait_busy_clear();
      chk(push_n - p0 == 2 && done_n - d0 == 1, "R3 triggered burst", push_n - p0, 2);
      chk(push_dat[p0[7:0]] == fill(24'h100) && push_dat[p0[7:0]+8'd1] == fill(24'h104),
          "R4 burst data", push_dat[p0[7:0]+8'd1], fill(24'h104));
      chk(chctl_o == 32'h1, "R8 bits cleared", chctl_o, 32'h1);

      // R2/R4/R10 decrementing peripheral-to-memory with stalls
      rdy_mode = 1;
      q0 = pop_n; d0 = done_n;
      wr(2'd0, 32'h80); wr(2'd1, 32'h3);
      wr(2'd2, 32'h1100_0002);
      wait_busy_clear();
      chk(pop_n - q0 == 3 && done_n - d0 == 1, "R10 stalled count", pop_n - q0, 3);
      for (int k = 0; k < 3; k++)
         chk(pop_adr[q0[7:0] + 8'(k)] == 24'(32'h80 - 4 * k) &&
             mem[(32'h80 - 4 * k) >> 2] == (32'hA000_0000 | 32'(q0 + k)),
             "R4 decrement write", {8'h0, pop_adr[q0[7:0] + 8'(k)]}, 32'h80 - 4 * k);

      // R5 repeated blocks
      p0 = push_n; d0 = done_n;
      wr(2'd0, 32'h40); wr(2'd1, 32'h0003_0002);
      wr(2'd2, 32'h0100_0201);
      wait_busy_clear();
      chk(push_n - p0 == 6 && done_n - d0 == 1, "R5 block count", push_n - p0, 6);
      for (int k = 0; k < 6; k++)
         chk(push_adr[p0[7:0] + 8'(k)] == 24'(32'h40 + 4 * k) &&
             push_dat[p0[7:0] + 8'(k)] == fill(24'(32'h40 + 4 * k)),
             "R5 block address", {8'h0, push_adr[p0[7:0] + 8'(k)]}, 32'h40 + 4 * k);
      chk(base_o == 24'h58 && blkctl_o == 32'h2, "R5 final registers", {8'h0, base_o}, 32'h58);

      // R6 linked list incl. empty packet
      rdy_mode = 0;
      p0 = push_n; d0 = done_n;
      wr(2'd0, 32'h200);
      wr(2'd2, 32'h0100_0401);
      wait_busy_clear();
      chk(push_n - p0 == 3 && done_n - d0 == 1, "R6 list words", push_n - p0, 3);
      chk(push_adr[p0[7:0]] == 24'h204 && push_adr[p0[7:0]+8'd1] == 24'h208 &&
          push_adr[p0[7:0]+8'd2] == 24'h324, "R6 list addresses",
          {8'h0, push_adr[p0[7:0]+8'd2]}, 32'h324);
      chk(base_o == 24'hFF_FFFF, "R6 end marker", {8'h0, base_o}, 32'hFF_FFFF);

      // R7 error on start address
      p0 = push_n; d0 = done_n; e0 = err_n;
      wr(2'd0, 32'h80_0000); wr(2'd1, 32'h4);
      wr(2'd2, 32'h1100_0001);
      wait_busy_clear();
      chk(push_n == p0 && err_n - e0 == 1 && done_n == d0 && chctl_o == 32'h1,
          "R7 bad start", err_n - e0, 1);

      // R7 with R4 wrap: decrement below zero
      p0 = push_n; e0 = err_n;
      wr(2'd0, 32'h4); wr(2'd1, 32'h3);
      wr(2'd2, 32'h1100_0003);
      wait_busy_clear();
      chk(push_n - p0 == 2 && err_n - e0 == 1, "R7 wrap error", push_n - p0, 2);
      chk(push_adr[p0[7:0]+8'd1] == 24'h0, "R4 wrap address", {8'h0, push_adr[p0[7:0]+8'd1]}, 0);

      // R7 error on list link
      p0 = push_n; e0 = err_n; d0 = done_n;
      wr(2'd0, 32'h3A0);
      wr(2'd2, 32'h0100_0401);
      wait_busy_clear();
      chk(push_n - p0 == 1 && err_n - e0 == 1 && done_n == d0, "R7 list link error", err_n - e0, 1);

      // R9 cancel finishes the current block
      rdy_mode = 2;
      p0 = push_n; d0 = done_n;
      wr(2'd0, 32'h100); wr(2'd1, 32'h000A_0004);
      wr(2'd2, 32'h0100_0201);
      idle(4);
      wr(2'd2, 32'h0000_0201);
      idle(2);
      rdy_mode = 0;
      idle(30);
      chk(push_n - p0 == 4 && done_n == d0, "R9 cancel block", push_n - p0, 4);
      chk(blkctl_o == 32'h0009_0004 && !chctl_o[24], "R9 no further block", blkctl_o, 32'h0009_0004);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule